// File: doc/BRIEF.md
# Isochronous Block-Threshold Ring Buffer Controller

This block manages one circular buffer for an isochronous stream that lives in a shared byte-wide RAM. Software sets where the ring starts, how long it is and how large a transfer block is. The controller keeps a write offset and a read offset into the ring and turns each into a RAM address. It also keeps a full flag in hardware, because equal offsets alone cannot show whether the ring is empty or full.

From the offsets and the flag it derives the number of stored bytes and the number of free bytes. A producer and a consumer present one byte per strobe. A write into a full ring is refused, and so is a read from an empty ring. A block transfer may only begin when the ring can take a whole block (receive direction) or can supply one (transmit direction). Three status bits report whether a block is in progress, whether a protocol error was signalled, and whether a byte was lost to overflow.

Top module: `isoc_ring_ctl`

## Requirements
- R1: After reset both offsets are 0, the ring is empty (buf_empty=1, buf_full=0), valid_cnt is 0, free_cnt is cfg_depth+1, and status is 3'b000.
- R2: wr_addr equals cfg_base plus the write offset, and rd_addr equals cfg_base plus the read offset, both modulo 2^14. Each offset advances by one per accepted byte and returns to 0 after reaching cfg_depth.
- R3: valid_cnt is the number of stored bytes, from 0 to cfg_depth+1, and free_cnt equals cfg_depth+1 minus valid_cnt.
- R4: buf_full is 1 exactly when the stored count equals cfg_depth+1. buf_empty is 1 exactly when the stored count is 0.
- R5: wr_en is wr_stb gated by not full, and rd_en is rd_stb gated by not empty. A refused byte leaves its offset unchanged.
- R6: When wr_stb and rd_stb are high in the same cycle and the ring is neither full nor empty, both bytes are taken and the count stays the same. At full only the read is taken; at empty only the write is taken.
- R7: With cfg_rx=1, xfer_start is high only when start_req is high, no block is active, and free_cnt >= cfg_blk+1.
- R8: With cfg_rx=0, xfer_start is high only when start_req is high, no block is active, and valid_cnt >= cfg_blk+1.
- R9: status[0] (active) sets on the edge after xfer_start. It clears on the edge that ends the cfg_blk+1-th strobe on the transfer side (wr_stb when cfg_rx=1, rd_stb otherwise), counting strobes in the cycles after the start. start_req is ignored while active.
- R10: A wr_stb while full with cfg_fce=0 drops the byte and sets status[2] (overflow), which holds until cleared. With cfg_fce=1 the byte is refused and status[2] is not set.
- R11: perr_evt sets status[1], which holds until cleared. sts_clr clears status[1] and status[2] but not status[0]. A set event in the same cycle as sts_clr wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 14 | Ring start address in the byte RAM |
| cfg_depth | input | 13 | Ring length in bytes minus one |
| cfg_blk | input | 9 | Block length in bytes minus one |
| cfg_fce | input | 1 | Flow control enable; 1 suppresses the overflow flag |
| cfg_rx | input | 1 | 1: receive (blocks written into ring); 0: transmit (blocks read out) |
| start_req | input | 1 | Request to begin a block transfer |
| wr_stb | input | 1 | Producer byte strobe |
| rd_stb | input | 1 | Consumer byte strobe |
| perr_evt | input | 1 | Command protocol error event |
| sts_clr | input | 1 | Clear error and overflow status |
| wr_en | output | 1 | Accepted byte write to RAM |
| rd_en | output | 1 | Accepted byte read from RAM |
| wr_addr | output | 14 | RAM write address |
| rd_addr | output | 14 | RAM read address |
| xfer_start | output | 1 | Block transfer begins this cycle |
| buf_full | output | 1 | Ring is full |
| buf_empty | output | 1 | Ring is empty |
| valid_cnt | output | 14 | Stored byte count |
| free_cnt | output | 14 | Free byte count |
| status | output | 3 | {overflow, protocol error, active} |

## Verification
The two functions that can fall in the same cycle are the producer write and the consumer read, both acting on the shared full flag and the count. The bench drives both strobes together in three situations: a full ring, an empty ring and a partly filled ring. It compares wr_en, rd_en, the offsets and both counts against a byte-count model that never uses equal-pointer logic. Overflow detection can also meet a simultaneous read at full, and the bench checks that case too: the read is taken and the write is dropped.

// File: rtl/isoc_ring_pkg.sv
package isoc_ring_pkg;

  // Status word: bit 0 active, bit 1 protocol error, bit 2 overflow.
  typedef struct packed {
    logic ovf;
    logic perr;
    logic act;
  } ring_sts_t;

  // Advance an offset by one, wrapping to zero after the last slot.
  function automatic logic [31:0] ring_step(input logic [31:0] p, input logic [31:0] last);
    return (p == last) ? 32'd0 : p + 32'd1;
  endfunction

  // Number of bytes held, given both offsets, the last slot and the full flag.
  function automatic logic [31:0] ring_fill(input logic [31:0] w, input logic [31:0] r,
                                            input logic [31:0] last, input logic bf);
    logic [31:0] span;
    span = last + 32'd1;
    if (w == r) return bf ? span : 32'd0;
    if (w > r) return w - r;
    return span - r + w;
  endfunction

endpackage

// File: rtl/isoc_ring_ptr.sv
module isoc_ring_ptr #(
  parameter int OFS_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [OFS_W-1:0] last,
  output logic [OFS_W-1:0] ptr,
  output logic [OFS_W-1:0] nxt
);
  assign nxt = OFS_W'(isoc_ring_pkg::ring_step(32'(ptr), 32'(last)));

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= nxt;
  end
endmodule

// File: rtl/isoc_ring_level.sv
module isoc_ring_level #(
  parameter int OFS_W = 13,
  localparam int CNT_W = OFS_W + 1
) (
  input  logic [OFS_W-1:0] wptr,
  input  logic [OFS_W-1:0] rptr,
  input  logic [OFS_W-1:0] last,
  input  logic             bf,
  output logic [CNT_W-1:0] valid,
  output logic [CNT_W-1:0] space,
  output logic             at_full,
  output logic             at_empty
);
  logic [CNT_W-1:0] span;

  assign span     = CNT_W'(last) + CNT_W'(1);
  assign valid    = CNT_W'(isoc_ring_pkg::ring_fill(32'(wptr), 32'(rptr), 32'(last), bf));
  assign space    = span - valid;
  assign at_full  = (wptr == rptr) && bf;
  assign at_empty = (wptr == rptr) && !bf;
endmodule

// File: rtl/isoc_ring_status.sv
module isoc_ring_status #(
  parameter int BLK_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             side_stb,
  input  logic [BLK_W-1:0] blk,
  input  logic             perr_evt,
  input  logic             ovf_evt,
  input  logic             clr,
  output logic             active,
  output logic [2:0]       status
);
  import isoc_ring_pkg::*;

  ring_sts_t        sts;
  logic [BLK_W-1:0] done_cnt;
  logic             last_byte;

  assign last_byte = active && side_stb && (done_cnt == blk);
  assign active    = sts.act;
  assign status    = sts;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts      <= '0;
      done_cnt <= '0;
    end else begin
      if (start) begin
        sts.act  <= 1'b1;
        done_cnt <= '0;
      end else if (last_byte) begin
        sts.act  <= 1'b0;
      end else if (active && side_stb) begin
        done_cnt <= done_cnt + BLK_W'(1);
      end
      if (perr_evt)  sts.perr <= 1'b1;
      else if (clr)  sts.perr <= 1'b0;
      if (ovf_evt)   sts.ovf  <= 1'b1;
      else if (clr)  sts.ovf  <= 1'b0;
    end
  end
endmodule

// File: rtl/isoc_ring_ctl.sv
module isoc_ring_ctl #(
  parameter int OFS_W = 13,
  parameter int ADR_W = 14,
  parameter int BLK_W = 9,
  localparam int CNT_W = OFS_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADR_W-1:0] cfg_base,
  input  logic [OFS_W-1:0] cfg_depth,
  input  logic [BLK_W-1:0] cfg_blk,
  input  logic             cfg_fce,
  input  logic             cfg_rx,
  input  logic             start_req,
  input  logic             wr_stb,
  input  logic             rd_stb,
  input  logic             perr_evt,
  input  logic             sts_clr,
  output logic             wr_en,
  output logic             rd_en,
  output logic [ADR_W-1:0] wr_addr,
  output logic [ADR_W-1:0] rd_addr,
  output logic             xfer_start,
  output logic             buf_full,
  output logic             buf_empty,
  output logic [CNT_W-1:0] valid_cnt,
  output logic [CNT_W-1:0] free_cnt,
  output logic [2:0]       status
);
  logic [OFS_W-1:0] wptr, rptr, wnxt, rnxt;
  logic             bf;
  logic             active;
  logic             side_stb;
  logic             ovf_evt;
  logic [CNT_W-1:0] need, avail;
  logic             makes_full, makes_empty;

  isoc_ring_ptr #(.OFS_W(OFS_W)) u_wptr (
    .clk(clk), .rst_n(rst_n), .adv(wr_en), .last(cfg_depth), .ptr(wptr), .nxt(wnxt));
  isoc_ring_ptr #(.OFS_W(OFS_W)) u_rptr (
    .clk(clk), .rst_n(rst_n), .adv(rd_en), .last(cfg_depth), .ptr(rptr), .nxt(rnxt));

  isoc_ring_level #(.OFS_W(OFS_W)) u_level (
    .wptr(wptr), .rptr(rptr), .last(cfg_depth), .bf(bf),
    .valid(valid_cnt), .space(free_cnt), .at_full(buf_full), .at_empty(buf_empty));

  // Byte acceptance: refuse writes into a full ring and reads from an empty one.
  assign wr_en   = wr_stb && !buf_full;
  assign rd_en   = rd_stb && !buf_empty;
  assign ovf_evt = wr_stb && buf_full && !cfg_fce;

  assign wr_addr = cfg_base + ADR_W'(wptr);
  assign rd_addr = cfg_base + ADR_W'(rptr);

  // Full flag: set by the write that closes the gap, cleared by the read that empties.
  assign makes_full  = wr_en && !rd_en && (wnxt == rptr);
  assign makes_empty = rd_en && !wr_en && (rnxt == wptr);

  always_ff @(posedge clk) begin
    if (!rst_n)           bf <= 1'b0;
    else if (makes_full)  bf <= 1'b1;
    else if (makes_empty) bf <= 1'b0;
  end

  // Block threshold on free space (receive) or stored bytes (transmit).
  assign need       = CNT_W'(cfg_blk) + CNT_W'(1);
  assign avail      = cfg_rx ? free_cnt : valid_cnt;
  assign xfer_start = start_req && !active && (avail >= need);
  assign side_stb   = cfg_rx ? wr_stb : rd_stb;

  isoc_ring_status #(.BLK_W(BLK_W)) u_status (
    .clk(clk), .rst_n(rst_n), .start(xfer_start), .side_stb(side_stb), .blk(cfg_blk),
    .perr_evt(perr_evt), .ovf_evt(ovf_evt), .clr(sts_clr), .active(active), .status(status));
endmodule

// File: rtl/isoc_ring_chk.sv
module isoc_ring_chk #(
  parameter int OFS_W = 13,
  parameter int ADR_W = 14,
  parameter int BLK_W = 9,
  localparam int CNT_W = OFS_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [OFS_W-1:0] cfg_depth,
  input logic [BLK_W-1:0] cfg_blk,
  input logic             cfg_fce,
  input logic             cfg_rx,
  input logic             wr_stb,
  input logic             rd_stb,
  input logic             wr_en,
  input logic             rd_en,
  input logic [ADR_W-1:0] wr_addr,
  input logic [ADR_W-1:0] rd_addr,
  input logic             xfer_start,
  input logic             buf_full,
  input logic             buf_empty,
  input logic [CNT_W-1:0] valid_cnt,
  input logic [CNT_W-1:0] free_cnt,
  input logic [2:0]       status
);
  logic [CNT_W-1:0] span;
  assign span = CNT_W'(cfg_depth) + CNT_W'(1);

  p_full_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> (valid_cnt == span) && (free_cnt == '0));

  p_empty_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_empty |-> (valid_cnt == '0) && (free_cnt == span));

  p_hold_wr_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && wr_stb) |=> $stable(wr_addr));

  p_hold_rd_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_empty && rd_stb) |=> $stable(rd_addr));

  p_both_keep_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |=> $stable(valid_cnt));

  p_rx_threshold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && cfg_rx) |-> (free_cnt > CNT_W'(cfg_blk)));

  p_tx_threshold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !cfg_rx) |-> (valid_cnt > CNT_W'(cfg_blk)));

  p_start_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> !status[0]);

  p_start_sets_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> status[0]);

  p_ovf_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && buf_full && !cfg_fce) |=> status[2]);

  p_ovf_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> $past(wr_stb && buf_full && !cfg_fce));
endmodule

bind isoc_ring_ctl isoc_ring_chk #(.OFS_W(OFS_W), .ADR_W(ADR_W), .BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_blk(cfg_blk), .cfg_fce(cfg_fce),
  .cfg_rx(cfg_rx), .wr_stb(wr_stb), .rd_stb(rd_stb), .wr_en(wr_en), .rd_en(rd_en),
  .wr_addr(wr_addr), .rd_addr(rd_addr), .xfer_start(xfer_start), .buf_full(buf_full),
  .buf_empty(buf_empty), .valid_cnt(valid_cnt), .free_cnt(free_cnt), .status(status));

// File: tb/isoc_ring_ctl_test.sv
`timescale 1ns/1ps
module isoc_ring_ctl_test;
  localparam int DEPTH = 15;
  localparam int SIZE  = DEPTH + 1;
  localparam int BLK   = 3;
  localparam logic [13:0] BASE = 14'h3FFA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_fce = 1'b1, cfg_rx = 1'b0;
  logic        start_req = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0, perr_evt = 1'b0, sts_clr = 1'b0;
  logic        wr_en, rd_en, xfer_start, buf_full, buf_empty;
  logic [13:0] wr_addr, rd_addr, valid_cnt, free_cnt;
  logic [2:0]  status;

  int total = 0, bad = 0;
  int m_w = 0, m_r = 0, m_cnt = 0, m_bc = 0;
  bit m_act = 0, m_perr = 0, m_ovf = 0, done = 0;

  always #2 clk = ~clk;

  isoc_ring_ctl uut (
    .clk(clk), .rst_n(rst_n), .cfg_base(BASE), .cfg_depth(13'(DEPTH)), .cfg_blk(9'(BLK)),
    .cfg_fce(cfg_fce), .cfg_rx(cfg_rx), .start_req(start_req), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .perr_evt(perr_evt), .sts_clr(sts_clr), .wr_en(wr_en), .rd_en(rd_en), .wr_addr(wr_addr),
    .rd_addr(rd_addr), .xfer_start(xfer_start), .buf_full(buf_full), .buf_empty(buf_empty),
    .valid_cnt(valid_cnt), .free_cnt(free_cnt), .status(status));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, check the combinational outputs,
  // advance the model, then check the registered status after the rising edge.
  task automatic step(input bit wr, input bit rd, input bit req, input bit pe, input bit clr);
    bit ewr, erd, est;
    int side;
    @(negedge clk);
    wr_stb = wr; rd_stb = rd; start_req = req; perr_evt = pe; sts_clr = clr;
    #1;
    ewr = wr && (m_cnt < SIZE);
    erd = rd && (m_cnt > 0);
    chk((wr && rd) ? "R6 wr_en" : "R5 wr_en", int'(wr_en), int'(ewr));
    chk((wr && rd) ? "R6 rd_en" : "R5 rd_en", int'(rd_en), int'(erd));
    chk("R2 wr_addr", int'(wr_addr), (int'(BASE) + m_w) % 16384);
    chk("R2 rd_addr", int'(rd_addr), (int'(BASE) + m_r) % 16384);
    chk("R3 valid_cnt", int'(valid_cnt), m_cnt);
    chk("R3 free_cnt", int'(free_cnt), SIZE - m_cnt);
    chk("R4 buf_full", int'(buf_full), int'(m_cnt == SIZE));
    chk("R4 buf_empty", int'(buf_empty), int'(m_cnt == 0));
    side = cfg_rx ? (SIZE - m_cnt) : m_cnt;
    est = req && !m_act && (side >= BLK + 1);
    chk(cfg_rx ? "R7 xfer_start" : "R8 xfer_start", int'(xfer_start), int'(est));
    if (est) begin
      m_act = 1; m_bc = 0;
    end else if (m_act && (cfg_rx ? wr : rd)) begin
      if (m_bc == BLK) m_act = 0; else m_bc++;
    end
    if (pe) m_perr = 1; else if (clr) m_perr = 0;
    if (wr && m_cnt == SIZE && !cfg_fce) m_ovf = 1; else if (clr) m_ovf = 0;
    if (ewr) m_w = (m_w + 1) % SIZE;
    if (erd) m_r = (m_r + 1) % SIZE;
    m_cnt = m_cnt + int'(ewr) - int'(erd);
    @(posedge clk); #1;
    chk("R9 status.active", int'(status[0]), int'(m_act));
    chk("R11 status.perr", int'(status[1]), int'(m_perr));
    chk("R10 status.ovf", int'(status[2]), int'(m_ovf));
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk("R1 valid", int'(valid_cnt), 0);
    chk("R1 free", int'(free_cnt), SIZE);
    chk("R1 empty", int'(buf_empty), 1);
    chk("R1 full", int'(buf_full), 0);
    chk("R1 status", int'(status), 0);
    chk("R1 wr_addr", int'(wr_addr), int'(BASE));
    chk("R1 rd_addr", int'(rd_addr), int'(BASE));
  endtask

  // R2 R4 R5 R10 R11: fill past the 14-bit address wrap, then write at full.
  task automatic t_fill_overflow;
    cfg_rx = 0; cfg_fce = 1;
    for (int i = 0; i < SIZE; i++) step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);          // refused, flow control on: no overflow
    cfg_fce = 0;
    step(1, 0, 0, 0, 0);          // dropped, overflow latched
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1);          // cleared
    cfg_fce = 1;
  endtask

  // R6: both strobes at full, mid-level and empty.
  task automatic t_same_cycle;
    cfg_fce = 0;
    step(1, 1, 0, 0, 0);          // full: read taken, write dropped, overflow set
    step(1, 1, 0, 0, 0);          // mid: both taken
    step(0, 0, 0, 0, 1);
    cfg_fce = 1;
    while (m_cnt > 0) step(0, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0);          // empty: read refused
    step(1, 1, 0, 0, 0);          // empty: only write taken
  endtask

  // R8 R9: transmit threshold and block completion.
  task automatic t_tx_block;
    cfg_rx = 0;
    while (m_cnt < BLK) step(1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);          // one byte short
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);          // starts
    step(1, 0, 1, 0, 0);          // ignored while active
    for (int i = 0; i <= BLK; i++) step(0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
  endtask

  // R7 R9: receive threshold on free space.
  task automatic t_rx_block;
    cfg_rx = 1;
    while (m_cnt < SIZE - BLK) step(1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);          // free one short
    step(0, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0);          // starts
    for (int i = 0; i <= BLK; i++) step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
  endtask

  // R11: protocol error set/clear, clear leaves active alone.
  task automatic t_perr;
    cfg_rx = 0;
    while (m_cnt < BLK + 1) step(1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);          // active
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 1);          // set wins over clear
    step(0, 0, 0, 0, 1);          // cleared, still active
    for (int i = 0; i <= BLK; i++) step(0, 1, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_fill_overflow();
    t_same_cycle();
    t_tx_block();
    t_rx_block();
    t_perr();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule